// File: doc/BRIEF.md
# Boot Command Frame Responder

This block sits behind the byte receiver of a serial boot link and answers the host. Command bytes arrive on a byte-wide valid/ready receive port. Each accepted command produces one response frame on a matching valid/ready transmit port. The block accepts no new command until the whole response frame has left. The supported-device inquiry returns a frame built from a constant device table given as a parameter. The size byte and the zero-sum checksum are produced while the frame streams out, so no frame buffer is used.

Three selection commands each take one value byte. They record a device choice, a clock mode and a bit-rate code, and the block presents these values on output ports. A later repeat of a selection overwrites the earlier value. The program/erase transition command moves the block into a locked phase. In that phase only the status inquiry is answered normally, and every other command is refused with an error byte and changes nothing. The host is expected to send the selections in the order device, clock mode, bit rate. The block does not enforce that order.

Top module: `boot_cmd_responder`

## Requirements
- R1: After a synchronous active-high reset, rx_ready is 1, tx_valid is 0, prog_phase is 0, and sel_device, sel_clock and sel_rate are all 0x00.
- R2: Command 0x20 in the setup phase returns this frame: 0x30, a size byte, the device count, then for each table entry in table order a character-count byte equal to 4+NAME_LEN, four code bytes and NAME_LEN name bytes. The frame ends with a checksum byte. Table byte j is DEV_TABLE[W-1-8j -: 8], where W is the table width.
- R3: The size byte of the inquiry frame equals 1 + NUM_DEV*(5+NAME_LEN). It counts neither the 0x30 byte, nor itself, nor the checksum.
- R4: The 8-bit sum of all inquiry frame bytes, from 0x30 through the checksum, is 0x00.
- R5: In the setup phase, 0x10, 0x11 or 0x3F is followed by one value byte. The block answers 0x06 and shows the value on sel_device, sel_clock or sel_rate respectively.
- R6: A repeated selection command leaves the latest value in effect, and the other two selections keep their values.
- R7: Command 0x40 in the setup phase is answered with 0x06 and sets prog_phase to 1. prog_phase stays 1 until reset.
- R8: While prog_phase is 1, every command byte other than 0x4F is answered with 0x80 and consumes no value byte. This includes 0x10, 0x11, 0x3F, 0x20 and 0x40. prog_phase and the selection outputs do not change.
- R9: Command 0x4F in either phase returns two bytes: 0x5F, then 0x00 in the setup phase or 0x01 in the locked phase.
- R10: Any other command byte in the setup phase is answered with 0x80 and leaves prog_phase and the selection outputs unchanged.
- R11: While tx_valid is 1 and tx_ready is 0, tx_valid stays 1 and tx_data stays unchanged in the next cycle.
- R12: From the cycle the response starts until the cycle after its last byte is taken, rx_ready is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_data | input | 8 | Command or value byte from the host |
| rx_valid | input | 1 | rx_data holds a byte |
| rx_ready | output | 1 | Block can take a byte this cycle |
| tx_data | output | 8 | Response byte |
| tx_valid | output | 1 | tx_data holds a response byte |
| tx_ready | input | 1 | Host takes tx_data this cycle |
| prog_phase | output | 1 | Program/erase transition has been received |
| sel_device | output | 8 | Last recorded device selection |
| sel_clock | output | 8 | Last recorded clock mode selection |
| sel_rate | output | 8 | Last recorded bit-rate selection |

## Verification
A command byte taken at a clock edge puts the first response byte on tx_data in the same clock period. The selection value and prog_phase become visible after that same edge. Each later frame byte appears in the period after the edge that took the previous byte. rx_ready rises in the period after the edge that took the last byte. The bench drives inputs and samples outputs at the falling edge. It compares a response byte only in a period where tx_valid and tx_ready are both high. It compares the state outputs only after the last byte of a frame has gone, so every expected value is read in the period it is due. Random backpressure on tx_ready produces stall periods, and in those the bench confirms that the held byte does not move.

// File: rtl/boot_pkg.sv
package boot_pkg;
   localparam logic [7:0] CMD_SEL_DEV  = 8'h10;
   localparam logic [7:0] CMD_SEL_CLK  = 8'h11;
   localparam logic [7:0] CMD_SEL_RATE = 8'h3F;
   localparam logic [7:0] CMD_INQ      = 8'h20;
   localparam logic [7:0] CMD_PROG     = 8'h40;
   localparam logic [7:0] CMD_STATUS   = 8'h4F;

   localparam logic [7:0] RSP_INQ_CODE  = 8'h30;
   localparam logic [7:0] RSP_ACK_CODE  = 8'h06;
   localparam logic [7:0] RSP_ERR_CODE  = 8'h80;
   localparam logic [7:0] RSP_STAT_CODE = 8'h5F;

   typedef enum logic [1:0] {K_ERR, K_ACK, K_STAT, K_INQ} rsp_kind_t;
   typedef enum logic [1:0] {C_IDLE, C_ARG, C_SEND} ctl_st_t;
   typedef enum logic [1:0] {SL_DEV, SL_CLK, SL_RATE} sel_id_t;
   typedef enum logic [2:0] {F_HEAD, F_SIZE, F_COUNT, F_BODY, F_SUM} frm_st_t;
endpackage

// File: rtl/boot_dev_rom.sv
module boot_dev_rom #(
   parameter int NUM_DEV  = 2,
   parameter int NAME_LEN = 4,
   parameter int ENT_W    = 1,
   parameter int OFF_W    = 4,
   parameter logic [NUM_DEV*(4+NAME_LEN)*8-1:0] DEV_TABLE = '0
) (
   input  logic [ENT_W-1:0] ent,
   input  logic [OFF_W-1:0] pos,
   output logic [7:0]       rom_byte
);
   localparam int EB     = 4 + NAME_LEN;
   localparam int NBYTES = NUM_DEV * EB;
   localparam int TW     = NBYTES * 8;
   localparam int AW     = $clog2(NBYTES);

   logic [7:0]    mem [NBYTES];
   logic [AW-1:0] addr;

   for (genvar j = 0; j < NBYTES; j++) begin : g_rom
      assign mem[j] = DEV_TABLE[TW-1-8*j -: 8];
   end

   // pos counts from 1 (0 is the character-count slot)
   assign addr     = AW'(ent) * AW'(EB) + AW'(pos) - AW'(1);
   assign rom_byte = mem[addr];
endmodule

// File: rtl/boot_frame_gen.sv
module boot_frame_gen
   import boot_pkg::*;
#(
   parameter int NUM_DEV  = 2,
   parameter int NAME_LEN = 4,
   parameter logic [NUM_DEV*(4+NAME_LEN)*8-1:0] DEV_TABLE = '0
) (
   input  logic      clk,
   input  logic      rst,
   input  rsp_kind_t kind,
   input  logic      phase,
   input  logic      step,
   output logic [7:0] byte_out,
   output logic      last
);
   localparam int EB    = 4 + NAME_LEN;
   localparam int SIZE  = 1 + NUM_DEV * (EB + 1);
   localparam int ENT_W = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1;
   localparam int OFF_W = $clog2(EB + 1);

   if (NUM_DEV < 1 || NAME_LEN < 1 || SIZE > 255) begin : g_bad_cfg
      $error("boot_frame_gen: table shape does not fit an 8-bit size field");
   end

   frm_st_t          fs;
   logic [ENT_W-1:0] ent;
   logic [OFF_W-1:0] off;
   logic [7:0]       acc;
   logic [7:0]       rom_byte;

   boot_dev_rom #(
      .NUM_DEV(NUM_DEV), .NAME_LEN(NAME_LEN), .ENT_W(ENT_W),
      .OFF_W(OFF_W), .DEV_TABLE(DEV_TABLE)
   ) u_rom (
      .ent(ent), .pos(off), .rom_byte(rom_byte)
   );

   always_comb begin
      byte_out = 8'h00;
      last     = 1'b0;
      unique case (fs)
         F_HEAD: begin
            unique case (kind)
               K_ERR:  byte_out = RSP_ERR_CODE;
               K_ACK:  byte_out = RSP_ACK_CODE;
               K_STAT: byte_out = RSP_STAT_CODE;
               K_INQ:  byte_out = RSP_INQ_CODE;
            endcase
            last = (kind == K_ERR) || (kind == K_ACK);
         end
         F_SIZE: begin
            byte_out = (kind == K_STAT) ? {7'b0, phase} : 8'(SIZE);
            last     = (kind == K_STAT);
         end
         F_COUNT: byte_out = 8'(NUM_DEV);
         F_BODY:  byte_out = (off == '0) ? 8'(EB) : rom_byte;
         F_SUM: begin
            byte_out = 8'h00 - acc;
            last     = 1'b1;
         end
         default: byte_out = 8'h00;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst || (step && last)) begin
         fs  <= F_HEAD;
         ent <= '0;
         off <= '0;
         acc <= 8'h00;
      end else if (step) begin
         acc <= acc + byte_out;
         unique case (fs)
            F_HEAD:  fs <= F_SIZE;
            F_SIZE:  fs <= F_COUNT;
            F_COUNT: begin
               fs  <= F_BODY;
               ent <= '0;
               off <= '0;
            end
            F_BODY: begin
               if (off == OFF_W'(EB)) begin
                  off <= '0;
                  if (ent == ENT_W'(NUM_DEV - 1)) fs <= F_SUM;
                  else                           ent <= ent + 1'b1;
               end else begin
                  off <= off + 1'b1;
               end
            end
            default: fs <= F_HEAD;
         endcase
      end
   end
endmodule

// File: rtl/boot_cmd_ctrl.sv
module boot_cmd_ctrl
   import boot_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  logic [7:0] rx_data,
   input  logic       rx_valid,
   output logic       rx_ready,
   input  logic       tx_ready,
   input  logic       tx_last,
   output logic       tx_valid,
   output rsp_kind_t  kind,
   output logic       prog_phase,
   output logic [7:0] sel_device,
   output logic [7:0] sel_clock,
   output logic [7:0] sel_rate
);
   ctl_st_t st;
   sel_id_t pend;
   logic    rx_hs;

   assign rx_ready = (st != C_SEND);
   assign tx_valid = (st == C_SEND);
   assign rx_hs    = rx_ready && rx_valid;

   always_ff @(posedge clk) begin
      if (rst) begin
         st         <= C_IDLE;
         pend       <= SL_DEV;
         kind       <= K_ERR;
         prog_phase <= 1'b0;
         sel_device <= 8'h00;
         sel_clock  <= 8'h00;
         sel_rate   <= 8'h00;
      end else begin
         unique case (st)
            C_IDLE: if (rx_hs) begin
               st <= C_SEND;
               if (rx_data == CMD_STATUS) begin
                  kind <= K_STAT;
               end else if (prog_phase) begin
                  kind <= K_ERR;
               end else begin
                  unique case (rx_data)
                     CMD_SEL_DEV:  begin pend <= SL_DEV;  st <= C_ARG; end
                     CMD_SEL_CLK:  begin pend <= SL_CLK;  st <= C_ARG; end
                     CMD_SEL_RATE: begin pend <= SL_RATE; st <= C_ARG; end
                     CMD_INQ:      kind <= K_INQ;
                     CMD_PROG: begin
                        kind       <= K_ACK;
                        prog_phase <= 1'b1;
                     end
                     default:      kind <= K_ERR;
                  endcase
               end
            end
            C_ARG: if (rx_hs) begin
               unique case (pend)
                  SL_DEV:  sel_device <= rx_data;
                  SL_CLK:  sel_clock  <= rx_data;
                  default: sel_rate   <= rx_data;
               endcase
               kind <= K_ACK;
               st   <= C_SEND;
            end
            default: if (tx_ready && tx_last) st <= C_IDLE;
         endcase
      end
   end

   // R7
   phase_sticky_chk: assert property (@(posedge clk) disable iff (rst)
      prog_phase |=> prog_phase);

   // R8
   locked_sel_chk: assert property (@(posedge clk) disable iff (rst)
      prog_phase |=> ($stable(sel_device) && $stable(sel_clock) && $stable(sel_rate)));

   // R12
   rx_blocked_chk: assert property (@(posedge clk) disable iff (rst)
      (tx_valid && !tx_ready) |=> !rx_ready);
endmodule

// File: rtl/boot_cmd_responder.sv
module boot_cmd_responder
   import boot_pkg::*;
#(
   parameter int NUM_DEV  = 2,
   parameter int NAME_LEN = 4,
   parameter logic [NUM_DEV*(4+NAME_LEN)*8-1:0] DEV_TABLE = "DV01NAMADV02NAMB"
) (
   input  logic       clk,
   input  logic       rst,
   input  logic [7:0] rx_data,
   input  logic       rx_valid,
   output logic       rx_ready,
   output logic [7:0] tx_data,
   output logic       tx_valid,
   input  logic       tx_ready,
   output logic       prog_phase,
   output logic [7:0] sel_device,
   output logic [7:0] sel_clock,
   output logic [7:0] sel_rate
);
   rsp_kind_t kind;
   logic      tx_last;

   boot_cmd_ctrl u_ctrl (
      .clk(clk), .rst(rst),
      .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
      .tx_ready(tx_ready), .tx_last(tx_last), .tx_valid(tx_valid),
      .kind(kind), .prog_phase(prog_phase),
      .sel_device(sel_device), .sel_clock(sel_clock), .sel_rate(sel_rate)
   );

   boot_frame_gen #(
      .NUM_DEV(NUM_DEV), .NAME_LEN(NAME_LEN), .DEV_TABLE(DEV_TABLE)
   ) u_frame (
      .clk(clk), .rst(rst), .kind(kind), .phase(prog_phase),
      .step(tx_valid && tx_ready), .byte_out(tx_data), .last(tx_last)
   );

   // R11
   tx_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));
endmodule

// File: tb/sim_boot_cmd_responder.sv
`timescale 1ns/1ps
module sim_boot_cmd_responder;
   localparam int NUM_DEV  = 2;
   localparam int NAME_LEN = 4;
   localparam int EB       = 4 + NAME_LEN;
   localparam int TW       = NUM_DEV * EB * 8;
   localparam logic [TW-1:0] TABLE = "DV01NAMADV02NAMB";

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [7:0] rx_data = 8'h00;
   logic       rx_valid = 1'b0;
   logic       rx_ready;
   logic [7:0] tx_data;
   logic       tx_valid;
   logic       tx_ready = 1'b0;
   logic       prog_phase;
   logic [7:0] sel_device, sel_clock, sel_rate;

   always #4 clk = ~clk;

   boot_cmd_responder #(.NUM_DEV(NUM_DEV), .NAME_LEN(NAME_LEN), .DEV_TABLE(TABLE)) u0 (
      .clk(clk), .rst(rst), .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
      .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
      .prog_phase(prog_phase), .sel_device(sel_device), .sel_clock(sel_clock),
      .sel_rate(sel_rate)
   );

   int         n_chk = 0;
   int         n_bad = 0;
   logic [7:0] expq [0:63];
   int         exp_len;
   logic       m_phase;
   logic [7:0] m_dev, m_clk, m_rate;
   int         bp = 30;

   task automatic chk(input bit ok, input string req, input int act, input int expv);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
      end
   endtask

   function automatic logic [7:0] tbl_byte(input int j);
      return TABLE[TW-1-8*j -: 8];
   endfunction

   // R2 R3 R4: expected inquiry frame
   task automatic build_inq();
      logic [7:0] s;
      int k;
      k = 0;
      expq[k++] = 8'h30;
      expq[k++] = 8'(1 + NUM_DEV * (EB + 1));
      expq[k++] = 8'(NUM_DEV);
      for (int e = 0; e < NUM_DEV; e++) begin
         expq[k++] = 8'(EB);
         for (int b = 0; b < EB; b++) expq[k++] = tbl_byte(e * EB + b);
      end
      s = 8'h00;
      for (int i = 0; i < k; i++) s = s + expq[i];
      expq[k++] = 8'h00 - s;
      exp_len = k;
   endtask

   task automatic put(input logic [7:0] b);
      @(negedge clk);
      rx_valid = 1'b1;
      rx_data  = b;
      while (!rx_ready) @(negedge clk);
      @(negedge clk);
      rx_valid = 1'b0;
   endtask

   task automatic take(input string req);
      int         i;
      bit         held;
      logic [7:0] hv;
      i = 0;
      held = 1'b0;
      while (i < exp_len) begin
         if (held) begin
            chk(tx_valid && tx_data == hv, "R11 hold", int'(tx_data), int'(hv));
            held = 1'b0;
         end
         tx_ready = (($urandom % 100) >= bp);
         if (tx_valid) begin
            if (i == 0) chk(rx_ready == 1'b0, "R12 rx blocked", int'(rx_ready), 0);
            if (tx_ready) begin
               chk(tx_data == expq[i], req, int'(tx_data), int'(expq[i]));
               i++;
            end else begin
               held = 1'b1;
               hv   = tx_data;
            end
         end
         @(negedge clk);
      end
      tx_ready = 1'b0;
      chk(rx_ready && !tx_valid, "R12 frame end", {rx_ready, tx_valid}, 2);
   endtask

   task automatic state_chk(input string req);
      chk(prog_phase == m_phase, {req, " phase"}, int'(prog_phase), int'(m_phase));
      chk({sel_device, sel_clock, sel_rate} == {m_dev, m_clk, m_rate}, {req, " sels"},
          int'({sel_device, sel_clock, sel_rate}), int'({m_dev, m_clk, m_rate}));
   endtask

   task automatic do_cmd(input logic [7:0] c, input logic [7:0] arg);
      string req;
      put(c);
      if (c == 8'h4F) begin
         req = "R9 status";
         expq[0] = 8'h5F; expq[1] = {7'b0, m_phase}; exp_len = 2;
      end else if (m_phase) begin
         req = "R8 locked";
         expq[0] = 8'h80; exp_len = 1;
      end else begin
         exp_len = 1;
         expq[0] = 8'h06;
         case (c)
            8'h10: begin req = "R5 R6 sel dev";  put(arg); m_dev  = arg; end
            8'h11: begin req = "R5 R6 sel clk";  put(arg); m_clk  = arg; end
            8'h3F: begin req = "R5 R6 sel rate"; put(arg); m_rate = arg; end
            8'h20: begin req = "R2 R3 R4 inquiry"; build_inq(); end
            8'h40: begin req = "R7 prog"; m_phase = 1'b1; end
            default: begin req = "R10 unknown"; expq[0] = 8'h80; end
         endcase
      end
      take(req);
      state_chk(req);
   endtask

   function automatic logic [7:0] rand_cmd();
      logic [7:0] u;
      case ($urandom % 7)
         0: return 8'h10;
         1: return 8'h11;
         2: return 8'h3F;
         3: return 8'h20;
         4: return 8'h4F;
         default: begin
            u = 8'($urandom);
            if (u == 8'h10 || u == 8'h11 || u == 8'h3F || u == 8'h20 ||
                u == 8'h40 || u == 8'h4F) u = 8'h55;
            return u;
         end
      endcase
   endfunction

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      finish_run();
   end

   initial begin
      void'($urandom(32'd4242));
      m_phase = 1'b0; m_dev = 8'h00; m_clk = 8'h00; m_rate = 8'h00;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R1 reset state
      chk(rx_ready && !tx_valid, "R1 handshake", {rx_ready, tx_valid}, 2);
      state_chk("R1 reset");

      bp = 0;  do_cmd(8'h20, 8'h00);
      bp = 60; do_cmd(8'h20, 8'h00);
      do_cmd(8'h4F, 8'h00);
      do_cmd(8'h10, 8'hA5);
      do_cmd(8'h11, 8'h03);
      do_cmd(8'h3F, 8'h7E);
      do_cmd(8'h11, 8'h09);     // R6 repeat keeps the latest
      do_cmd(8'h00, 8'h00);     // R10
      do_cmd(8'hFF, 8'h00);     // R10
      bp = 30;
      for (int n = 0; n < 40; n++) do_cmd(rand_cmd(), 8'($urandom));
      do_cmd(8'h40, 8'h00);     // R7
      do_cmd(8'h4F, 8'h00);     // R9 locked status
      do_cmd(8'h10, 8'h00);     // R8
      do_cmd(8'h11, 8'h00);
      do_cmd(8'h3F, 8'h00);
      do_cmd(8'h20, 8'h00);
      do_cmd(8'h40, 8'h00);
      for (int n = 0; n < 30; n++) do_cmd(rand_cmd(), 8'($urandom));
      finish_run();
   end
endmodule